// File: doc/BRIEF.md
# Clock Output Enable Gate Bank

This block sits after a clock selection stage and fans one clock out to a set of output pairs. Each pair has a true and a complement output and its own active-high enable. The outputs are grouped into banks, and each bank carries a format flag that marks its pairs as differential or single-ended. On a differential pair the complement is the inverted clock. On a single-ended pair the complement is a second in-phase copy, so one pair gives two single-ended clocks.

The enables are not applied as they arrive. Each one is captured on the falling edge of the clock, while the clock is low, and only that captured value gates the output. An output can therefore only start or stop at a rising edge, and it never emits a high pulse shorter than the clock's high phase. A disabled pair is parked. A differential pair parks with true low and complement high. A single-ended pair parks with both outputs low. Reset clears every captured enable, and the first real value is taken at the first falling edge after reset is released.

Top module: `oeg_bank`

## Requirements
- R1: While reset is asserted, and in the clock high phase before the first falling edge after reset is released, every pair is in its parked state, whatever the enables are.
- R2: An enabled pair drives its true output equal to the clock: high in the high phase and low in the low phase.
- R3: A change on an enable bit changes its pair only after the next falling clock edge. A change made during a high phase does not alter the outputs in the rest of that phase.
- R4: A disabled pair in a differential bank (format flag 0) holds true low and complement high.
- R5: A disabled pair in a single-ended bank (format flag 1) holds both true and complement low.
- R6: An enabled pair in a differential bank drives its complement output as the inverse of the clock.
- R7: An enabled pair in a single-ended bank drives its complement output equal to the clock, in phase with the true output.
- R8: Every pair follows only its own enable bit. Pair i belongs to bank i / PAIRS_PER_BANK, and format flag bit b applies to bank b.
- R9: The true output never produces a high pulse shorter than the clock high phase. Its level stays constant from each rising clock edge to the following falling edge.

Top module port order follows the table below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Selected clock that drives every pair |
| rst_n | input | 1 | Asynchronous active-low reset of the captured enables |
| oe_req | input | NUM_PAIRS | Active-high enable request, one bit per pair |
| bank_se | input | NUM_BANKS | Format flag per bank: 0 differential, 1 single-ended |
| q_true | output | NUM_PAIRS | True output of each pair |
| q_comp | output | NUM_PAIRS | Complement output of each pair |

## Verification
Each pair holds one bit of state, the captured enable. A wrong bit shows at the ports in the very next clock high phase: the true output is stuck low or runs when it should not, and a differential complement takes the wrong parked level. A capture on the wrong edge or from the wrong bit shows as an output that responds in the same high phase as its enable change, or follows a neighbour's enable. Because the complement is formed from the format flag, a mixed-up bank mapping shows at once on the complement during both clock phases.

// File: rtl/oeg_pkg.sv
package oeg_pkg;

  typedef enum logic {
    FMT_DIFF = 1'b0,
    FMT_SE   = 1'b1
  } out_fmt_e;

  function automatic int unsigned bank_of(input int unsigned pair_idx,
                                          input int unsigned per_bank);
    return pair_idx / per_bank;
  endfunction

endpackage

// File: rtl/oeg_en_sync.sv
module oeg_en_sync #(
  parameter int unsigned WIDTH = 10
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] oe_req,
  output logic [WIDTH-1:0] oe_cap,
  output logic             armed
);

  // Capture in the low phase so the gate can only change while clk_in is low.
  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      oe_cap <= '0;
    end else begin
      oe_cap <= oe_req;
    end
  end

  // Checker qualifier: one falling edge has passed since reset.
  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
    end
  end

endmodule

// File: rtl/oeg_pair_drv.sv
module oeg_pair_drv
  import oeg_pkg::*;
(
  input  logic     clk_in,
  input  logic     rst_n,
  input  logic     armed,
  input  logic     oe_req_bit,
  input  logic     en_q,
  input  out_fmt_e fmt,
  output logic     q_true,
  output logic     q_comp
);

  always_comb begin
    q_true = clk_in & en_q;
    unique case (fmt)
      FMT_SE:   q_comp = clk_in & en_q;
      default:  q_comp = ~(clk_in & en_q);
    endcase
  end

  // Sampled just before a falling edge: clk_in is high there.
  p_true_follows_oe_r3: assert property (@(negedge clk_in) disable iff (!rst_n)
    armed |-> (q_true == $past(oe_req_bit)));

  p_diff_park_r4: assert property (@(negedge clk_in) disable iff (!rst_n)
    (fmt == FMT_DIFF && !q_true) |-> q_comp);

  p_diff_inverse_r6: assert property (@(negedge clk_in) disable iff (!rst_n)
    (fmt == FMT_DIFF && q_true) |-> !q_comp);

  p_se_copy_r7: assert property (@(negedge clk_in) disable iff (!rst_n)
    (fmt == FMT_SE) |-> (q_comp == q_true));

  p_low_phase_r2: assert property (@(posedge clk_in) disable iff (!rst_n)
    !q_true);

endmodule

// File: rtl/oeg_bank.sv
module oeg_bank
  import oeg_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 10,
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic                 clk_in,
  input  logic                 rst_n,
  input  logic [NUM_PAIRS-1:0] oe_req,
  input  logic [NUM_BANKS-1:0] bank_se,
  output logic [NUM_PAIRS-1:0] q_true,
  output logic [NUM_PAIRS-1:0] q_comp
);

  localparam int unsigned PAIRS_PER_BANK = NUM_PAIRS / NUM_BANKS;

  logic [NUM_PAIRS-1:0] oe_cap;
  logic                 armed;

  oeg_en_sync #(.WIDTH(NUM_PAIRS)) en_sync_i (
    .clk_in (clk_in),
    .rst_n  (rst_n),
    .oe_req (oe_req),
    .oe_cap (oe_cap),
    .armed  (armed)
  );

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
    localparam int unsigned BANK = bank_of(i, PAIRS_PER_BANK);
    out_fmt_e fmt_i;
    assign fmt_i = bank_se[BANK] ? FMT_SE : FMT_DIFF;

    oeg_pair_drv drv_i (
      .clk_in     (clk_in),
      .rst_n      (rst_n),
      .armed      (armed),
      .oe_req_bit (oe_req[i]),
      .en_q       (oe_cap[i]),
      .fmt        (fmt_i),
      .q_true     (q_true[i]),
      .q_comp     (q_comp[i])
    );
  end

  // R1: while reset is held, no true output is high.
  p_reset_quiet_r1: assert property (@(negedge clk_in)
    !rst_n |-> (q_true == '0));

endmodule

// File: tb/oeg_bank_tb_top.sv
`timescale 1ns/100ps
module oeg_bank_tb_top;

  localparam int unsigned NP = 10;
  localparam int unsigned NB = 2;
  localparam int unsigned PB = NP / NB;

  logic          clk_in = 1'b0;
  logic          rst_n  = 1'b0;
  logic [NP-1:0] oe_req = '1;
  logic [NB-1:0] bank_se = '0;
  logic [NP-1:0] q_true, q_comp;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [NP-1:0] en_model = '0;

  always #2.5 clk_in = ~clk_in;

  oeg_bank #(.NUM_PAIRS(NP), .NUM_BANKS(NB)) dut_i (
    .clk_in (clk_in),
    .rst_n  (rst_n),
    .oe_req (oe_req),
    .bank_se(bank_se),
    .q_true (q_true),
    .q_comp (q_comp)
  );

  function automatic logic [NP-1:0] se_mask();
    logic [NP-1:0] m;
    for (int i = 0; i < NP; i++) m[i] = bank_se[i / PB];
    return m;
  endfunction

  // High phase: true = enable; diff comp = ~enable; se comp = enable.
  task automatic check_high(input string req);
    logic [NP-1:0] et, ec, se;
    se = se_mask();
    et = en_model;
    ec = (se & en_model) | (~se & ~en_model);
    checks++;
    if (q_true !== et || q_comp !== ec) begin
      errors++;
      $display("FAIL %s high phase: true=%b comp=%b expected true=%b comp=%b",
               req, q_true, q_comp, et, ec);
    end
  endtask

  // Low phase: true low; diff comp high; se comp low.
  task automatic check_low(input string req);
    logic [NP-1:0] ec;
    ec = ~se_mask();
    checks++;
    if (q_true !== '0 || q_comp !== ec) begin
      errors++;
      $display("FAIL %s low phase: true=%b comp=%b expected true=%b comp=%b",
               req, q_true, q_comp, {NP{1'b0}}, ec);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state with all enables requested, both formats.
    repeat (2) @(posedge clk_in);
    #0.6 check_high("R1 reset diff");
    bank_se = '1;
    #0.6 check_high("R1 reset se");
    @(negedge clk_in); #1.2 check_low("R1 reset low");
    bank_se = 2'b01;
    @(posedge clk_in); #0.6;
    rst_n = 1'b1;
    #0.6 check_high("R1 first high phase after release");
    @(negedge clk_in); en_model = oe_req;
    #1.2 check_low("R1");

    // Sweep formats and enable patterns; changes land mid high phase.
    for (int f = 0; f < 4; f++) begin
      bank_se = f[NB-1:0];
      for (int k = 0; k < 300; k++) begin
        @(posedge clk_in); #0.6;
        check_high("R2 R4 R5 R6 R7 R8");
        oe_req = NP'((k * 613) ^ (k << 3) ^ (f * 91));
        #0.8 check_high("R3 R9 mid-phase change");
        @(negedge clk_in); en_model = oe_req;
        #1.2 check_low("R2 R6 R7");
      end
    end

    // R8: walking single enable, each format, shows no cross-coupling.
    for (int f = 0; f < 4; f++) begin
      bank_se = f[NB-1:0];
      for (int i = 0; i < NP; i++) begin
        @(posedge clk_in); #0.6;
        oe_req = NP'(1) << i;
        @(negedge clk_in); en_model = oe_req;
        @(posedge clk_in); #0.6 check_high("R8 walking one");
      end
    end

    // R4 R5: all disabled in mixed formats.
    bank_se = 2'b10;
    @(posedge clk_in); #0.6; oe_req = '0;
    @(negedge clk_in); en_model = oe_req;
    @(posedge clk_in); #0.6 check_high("R4 R5 all parked");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule